// File: doc/BRIEF.md
# Dual-Style Host Register Port

This block is a slave port through which an external 8-bit host reads and writes a small set of internal registers. Two pins pick the bus style at run time. In the separate-strobe style the host has a read strobe and a write strobe, both active low. In the data-strobe style it has one active-low strobe and a direction line. Each style can run in an asynchronous variant, where the control pins pass through a two-flop synchronizer into the core clock, or in a synchronous variant, where the host bus is clocked by the core clock and takes one capture stage.

The address is captured on the falling edge of the address-latch input. A read drives the data bus through a separate output-enable. A write commits on the trailing edge of its strobe. A completion handshake reports that an access is in progress. It is active high in the separate-strobe style and active low in the data-strobe style.

The register bank has a command register and a row of sticky status registers fed by alarm inputs. Bit 7 of the command register is the global interrupt enable, and it gates an active-low interrupt output.

Top module: `upi_port`

## Requirements
- R1: `type_sel[0]` picks the style (0 = separate strobes, 1 = data strobe) and `type_sel[1]` picks the timing (0 = asynchronous, 1 = synchronous). A strobe that goes low just before a clock edge enables the data bus by the following sample point in synchronous mode, and one clock later in asynchronous mode.
- R2: The address register takes the `addr` pins when the synchronized `ale` falls. Later changes on `addr` do not alter the target of an access.
- R3: While `cs_n` is high no access occurs. No write commits, `data_oe` stays 0 and `xfer_ack` stays at its idle level.
- R4: In the separate-strobe style, `rd_ds_n` low reads and `wr_rw` low writes. The write data is captured while the strobe is low and committed when the strobe rises.
- R5: In the data-strobe style, `rd_ds_n` low with `wr_rw` high reads, and `rd_ds_n` low with `wr_rw` low writes.
- R6: `xfer_ack` goes active one clock after an access is detected and stays active until the access ends. It is active high in the separate-strobe style and active low in the data-strobe style, and it idles at the opposite level.
- R7: `data_oe` is 1 only during a read. `data_out` is 0x00 whenever `data_oe` is 0.
- R8: The command register sits at address 0x00, is read/write and resets to 0x00. `ctrl_out` mirrors it.
- R9: Status register i is at address 0x20+i and is read-only. Each alarm bit sets its status bit, and the bit stays set. A completed read of a status register clears the bits that read returned, except bits whose alarm is still active.
- R10: `irq_n` is low exactly when command bit 7 is 1 and any status bit is set, with one clock of delay. It stays high while bit 7 is 0.
- R11: A read of an unmapped address returns 0x00. Writes to unmapped or status addresses change nothing. The handshake completes either way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the host clock in synchronous modes |
| rst_n | input | 1 | Asynchronous active-low reset |
| type_sel | input | 2 | Bus style and timing select |
| addr | input | 8 | Host address |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Read data toward the host |
| data_oe | output | 1 | Drive enable for the data pins |
| ale | input | 1 | Address latch / address strobe |
| cs_n | input | 1 | Chip select, active low |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| wr_rw | input | 1 | Write strobe (active low) or direction (1 = read) |
| xfer_ack | output | 1 | Completion handshake, polarity by style |
| irq_n | output | 1 | Interrupt, active low |
| alarm | input | 16 | Alarm inputs, 8 per status register |
| ctrl_out | output | 8 | Command register contents |

## Verification
A wrong address register shows at the next read as the contents of another register, or as 0x00, on `data_out`. A bad synchronizer path or bad style decode shows at once as `data_oe` or `xfer_ack` asserting a clock early or late, or with the wrong polarity. Corruption in the status or command registers shows on `irq_n` one clock later and on the next read-back. The bench models every output each clock, so a fault becomes visible within a cycle or two of the event that caused it.

// File: rtl/upi_pkg.sv
package upi_pkg;
   // Control pins after synchronization, packed for one synchronizer instance
   typedef struct packed {
      logic cs_n;    // chip select
      logic strb_n;  // read strobe or data strobe
      logic dir;     // write strobe or read/write direction
      logic ale;     // address latch
   } upi_ctl_t;

   localparam int unsigned CTL_W = $bits(upi_ctl_t);
   localparam upi_ctl_t CTL_IDLE = '{cs_n: 1'b1, strb_n: 1'b1, dir: 1'b1, ale: 1'b0};

   function automatic logic mode_is_ds(input logic [1:0] sel);
      return sel[0];
   endfunction

   function automatic logic mode_is_sync(input logic [1:0] sel);
      return sel[1];
   endfunction
endpackage

// File: rtl/upi_sync.sv
module upi_sync #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bypass,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("upi_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("upi_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   // synchronous host timing uses only the capture stage
   assign q = bypass ? stg[0] : stg[STAGES-1];
endmodule

// File: rtl/upi_access.sv
module upi_access
   import upi_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ds_style,
   input  upi_ctl_t      ctl,
   input  logic [AW-1:0] addr_pin,
   input  logic [DW-1:0] data_pin,
   output logic          rd_act,
   output logic          wr_act,
   output logic          rd_end,
   output logic          wr_commit,
   output logic [AW-1:0] addr_lat,
   output logic [DW-1:0] wdata,
   output logic          ack
);
   logic          sel;
   logic          ale_q, rd_q, wr_q, ack_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;

   assign sel = !ctl.cs_n;

   always_comb begin
      if (ds_style) begin
         rd_act = sel && !ctl.strb_n && ctl.dir;
         wr_act = sel && !ctl.strb_n && !ctl.dir;
      end else begin
         rd_act = sel && !ctl.strb_n;
         wr_act = sel && !ctl.dir;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale_q   <= 1'b0;
         rd_q    <= 1'b0;
         wr_q    <= 1'b0;
         ack_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         ale_q <= ctl.ale;
         rd_q  <= rd_act;
         wr_q  <= wr_act;
         ack_q <= rd_act || wr_act;
         if (ale_q && !ctl.ale) addr_q <= addr_pin;
         if (wr_act) wdata_q <= data_pin;
      end
   end

   assign rd_end    = rd_q && !rd_act;
   assign wr_commit = wr_q && !wr_act;
   assign addr_lat  = addr_q;
   assign wdata     = wdata_q;
   assign ack       = ack_q;

   // R2: address register only moves on a latch falling edge
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ale_q && !ctl.ale) |=> $stable(addr_q));
   // R3: a deselected bus leaves the handshake idle next cycle
   p_no_cs_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.cs_n |=> !ack_q);
   // R6: a detected access is acknowledged on the following cycle
   p_ack_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act || wr_act) |=> ack_q);
endmodule

// File: rtl/upi_regs.sv
module upi_regs #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8,
   parameter int unsigned NUM_STAT = 2,
   parameter int unsigned STAT_BASE = 32,
   parameter int unsigned CMD_ADDR = 0,
   parameter int unsigned GIE_BIT = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          addr_lat,
   input  logic                   rd_act,
   input  logic                   rd_end,
   input  logic                   wr_commit,
   input  logic [DW-1:0]          wdata,
   input  logic [NUM_STAT*DW-1:0] alarm,
   output logic [DW-1:0]          rd_data,
   output logic [DW-1:0]          ctrl,
   output logic                   irq
);
   localparam logic [AW-1:0] CMD_A = AW'(CMD_ADDR);

   generate
      if (GIE_BIT >= DW) begin : g_bad_gie
         $error("upi_regs: GIE_BIT outside data width");
      end
      if (STAT_BASE + NUM_STAT > (1 << AW)) begin : g_bad_map
         $error("upi_regs: status block exceeds address space");
      end
      if (CMD_ADDR >= STAT_BASE && CMD_ADDR < STAT_BASE + NUM_STAT) begin : g_overlap
         $error("upi_regs: command address overlaps status block");
      end
      if (NUM_STAT < 1) begin : g_bad_num
         $error("upi_regs: NUM_STAT must be positive");
      end
   endgenerate

   logic [DW-1:0]          cmd_q, shown_q;
   logic [DW-1:0]          stat_q [NUM_STAT];
   logic [NUM_STAT-1:0]    hit;
   logic [NUM_STAT*DW-1:0] stat_flat;
   logic                   irq_q;

   generate
      for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat_dec
         assign hit[i] = (addr_lat == AW'(STAT_BASE + i));
         assign stat_flat[i*DW +: DW] = stat_q[i];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (addr_lat == CMD_A) rd_data = cmd_q;
      for (int i = 0; i < NUM_STAT; i++) begin
         if (hit[i]) rd_data = stat_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         shown_q <= '0;
         irq_q   <= 1'b0;
         for (int i = 0; i < NUM_STAT; i++) stat_q[i] <= '0;
      end else begin
         if (wr_commit && addr_lat == CMD_A) cmd_q <= wdata;
         if (rd_act) shown_q <= rd_data;
         for (int i = 0; i < NUM_STAT; i++) begin
            if (rd_end && hit[i])
               stat_q[i] <= (stat_q[i] & ~shown_q) | alarm[i*DW +: DW];
            else
               stat_q[i] <= stat_q[i] | alarm[i*DW +: DW];
         end
         irq_q <= cmd_q[GIE_BIT] && (|stat_flat);
      end
   end

   assign ctrl = cmd_q;
   assign irq  = irq_q;

   // R8: command register holds unless a write to its address commits
   p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_commit && addr_lat == CMD_A) |=> $stable(cmd_q));
   // R9: status bits never fall outside a completed read
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_end |=> ((stat_flat & $past(stat_flat)) == $past(stat_flat)));
   // R10: interrupt stays off while the enable bit was clear
   p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmd_q[GIE_BIT]) |-> !irq_q);
endmodule

// File: rtl/upi_port.sv
module upi_port
   import upi_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NUM_STAT = 2,
   parameter int unsigned STAT_BASE = 32,
   parameter int unsigned CMD_ADDR = 0,
   parameter int unsigned GIE_BIT = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             type_sel,
   input  logic [AW-1:0]          addr,
   input  logic [DW-1:0]          data_in,
   output logic [DW-1:0]          data_out,
   output logic                   data_oe,
   input  logic                   ale,
   input  logic                   cs_n,
   input  logic                   rd_ds_n,
   input  logic                   wr_rw,
   output logic                   xfer_ack,
   output logic                   irq_n,
   input  logic [NUM_STAT*DW-1:0] alarm,
   output logic [DW-1:0]          ctrl_out
);
   upi_ctl_t      ctl_raw, ctl_syn;
   logic          ds_style;
   logic          rd_act, wr_act, rd_end, wr_commit, ack, irq;
   logic [AW-1:0] addr_lat;
   logic [DW-1:0] wdata, rd_data;

   assign ds_style = mode_is_ds(type_sel);
   assign ctl_raw  = '{cs_n: cs_n, strb_n: rd_ds_n, dir: wr_rw, ale: ale};

   upi_sync #(
      .WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .bypass(mode_is_sync(type_sel)),
      .d(ctl_raw), .q(ctl_syn)
   );

   upi_access #(.AW(AW), .DW(DW)) u_access (
      .clk(clk), .rst_n(rst_n), .ds_style(ds_style), .ctl(ctl_syn),
      .addr_pin(addr), .data_pin(data_in),
      .rd_act(rd_act), .wr_act(wr_act), .rd_end(rd_end), .wr_commit(wr_commit),
      .addr_lat(addr_lat), .wdata(wdata), .ack(ack)
   );

   upi_regs #(
      .AW(AW), .DW(DW), .NUM_STAT(NUM_STAT), .STAT_BASE(STAT_BASE),
      .CMD_ADDR(CMD_ADDR), .GIE_BIT(GIE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr_lat(addr_lat), .rd_act(rd_act),
      .rd_end(rd_end), .wr_commit(wr_commit), .wdata(wdata), .alarm(alarm),
      .rd_data(rd_data), .ctrl(ctrl_out), .irq(irq)
   );

   assign data_oe  = rd_act;
   assign data_out = rd_act ? rd_data : '0;
   assign xfer_ack = ds_style ? !ack : ack;
   assign irq_n    = !irq;
endmodule

// File: tb/tb_upi_port.sv
module tb_upi_port;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  type_sel = 2'b00;
   logic [7:0]  addr = 8'h00, data_in = 8'h00;
   logic        ale = 1'b0, cs_n = 1'b1, rd_ds_n = 1'b1, wr_rw = 1'b1;
   logic [15:0] alarm = 16'h0000;
   logic [7:0]  data_out, ctrl_out;
   logic        data_oe, xfer_ack, irq_n;

   int n_cmp = 0, n_bad = 0;
   logic done_run = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   upi_port dut (
      .clk(clk), .rst_n(rst_n), .type_sel(type_sel), .addr(addr),
      .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .ale(ale),
      .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .xfer_ack(xfer_ack),
      .irq_n(irq_n), .alarm(alarm), .ctrl_out(ctrl_out)
   );

   // ---------------- behavioural reference ----------------
   // pin history: bit3 cs_n, bit2 strobe, bit1 dir/write, bit0 ale
   logic [3:0] h0 = 4'b1110, h1 = 4'b1110;
   logic [7:0] m_addr, m_cmd, m_shown, m_wdata;
   logic [7:0] m_stat [NS];
   logic       m_aleprev, m_rdprev, m_wrprev, m_done, m_irq;

   function automatic logic [3:0] seen();
      return type_sel[1] ? h0 : h1;
   endfunction
   function automatic logic m_rd(input logic [3:0] s);
      return type_sel[0] ? (!s[3] && !s[2] && s[1]) : (!s[3] && !s[2]);
   endfunction
   function automatic logic m_wr(input logic [3:0] s);
      return type_sel[0] ? (!s[3] && !s[2] && !s[1]) : (!s[3] && !s[1]);
   endfunction
   function automatic logic [7:0] m_mux(input logic [7:0] a);
      if (a == 8'h00) return m_cmd;
      if (a >= 8'h20 && a < 8'h20 + NS) return m_stat[a - 8'h20];
      return 8'h00;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h0 = 4'b1110; h1 = 4'b1110;
         m_addr = 0; m_cmd = 0; m_shown = 0; m_wdata = 0;
         for (int i = 0; i < NS; i++) m_stat[i] = 0;
         m_aleprev = 0; m_rdprev = 0; m_wrprev = 0; m_done = 0; m_irq = 0;
      end else begin
         logic [3:0] s;
         logic r, w, anyst;
         logic [7:0] n_addr, n_cmd, n_shown;
         s = seen();
         r = m_rd(s);
         w = m_wr(s);
         n_addr = (m_aleprev && !s[0]) ? addr : m_addr;
         n_shown = r ? m_mux(m_addr) : m_shown;
         n_cmd = (m_wrprev && !w && m_addr == 8'h00) ? m_wdata : m_cmd;
         anyst = 0;
         for (int i = 0; i < NS; i++) anyst = anyst | (m_stat[i] != 0);
         m_irq = m_cmd[7] && anyst;
         for (int i = 0; i < NS; i++) begin
            if (m_rdprev && !r && m_addr == 8'h20 + i)
               m_stat[i] = (m_stat[i] & ~m_shown) | alarm[i*8 +: 8];
            else
               m_stat[i] = m_stat[i] | alarm[i*8 +: 8];
         end
         if (w) m_wdata = data_in;
         m_addr = n_addr; m_shown = n_shown; m_cmd = n_cmd;
         m_aleprev = s[0]; m_rdprev = r; m_wrprev = w; m_done = r || w;
         h1 = h0; h0 = {cs_n, rd_ds_n, wr_rw, ale};
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock: sample at the falling edge, compare every output to the model
   task automatic tick();
      logic eo;
      @(negedge clk);
      eo = m_rd(seen());
      chk("R7 data_oe", data_oe, eo);
      chk("R4 data_out", data_out, eo ? m_mux(m_addr) : 8'h00);
      chk("R6 xfer_ack", xfer_ack, type_sel[0] ? !m_done : m_done);
      chk("R10 irq_n", irq_n, !m_irq);
      chk("R8 ctrl_out", ctrl_out, m_cmd);
   endtask

   task automatic xfer(input logic is_rd, input logic [7:0] a, input logic [7:0] a_after,
                       input logic [7:0] wd, input logic use_cs,
                       output logic [7:0] rv, output logic saw_ack);
      logic ds;
      ds = type_sel[0];
      addr = a; ale = 1; tick();
      ale = 0; tick(); tick(); tick();
      addr = a_after; tick();
      cs_n = !use_cs; data_in = wd;
      if (ds) wr_rw = is_rd;
      tick();
      if (ds || is_rd) rd_ds_n = 0; else wr_rw = 0;
      rv = 8'h00; saw_ack = 0;
      for (int k = 0; k < 6; k++) begin
         tick();
         if (data_oe) rv = data_out;
         if (xfer_ack === !ds) saw_ack = 1;
      end
      rd_ds_n = 1; wr_rw = 1;
      repeat (4) tick();
      cs_n = 1;
      repeat (3) tick();
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] rv; logic ak;
      xfer(0, a, a, d, 1, rv, ak);
      chk("R6 write handshake seen", ak, 1);
   endtask

   task automatic rd_exp(input string tag, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] rv; logic ak;
      xfer(1, a, a, 8'h00, 1, rv, ak);
      chk(tag, rv, exp);
      chk("R6 read handshake seen", ak, 1);
   endtask

   // R1: strobe-to-enable latency per timing variant
   task automatic lat_check(input string tag);
      addr = 8'h00; ale = 1; tick(); ale = 0; repeat (4) tick();
      cs_n = 0; wr_rw = 1; tick();
      rd_ds_n = 0; tick();
      chk(tag, data_oe, type_sel[1] ? 1 : 0);
      tick();
      chk(tag, data_oe, 1);
      rd_ds_n = 1; repeat (3) tick();
      cs_n = 1; repeat (3) tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_run) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv; logic ak;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R8 reset ctrl_out", ctrl_out, 8'h00);
      chk("R10 reset irq_n", irq_n, 1);
      chk("R7 reset data_oe", data_oe, 0);
      chk("R6 reset idle ack", xfer_ack, 0);

      // separate strobes, asynchronous
      type_sel = 2'b00; tick();
      wr(8'h00, 8'h5A);
      rd_exp("R8 command read-back", 8'h00, 8'h5A);
      xfer(1, 8'h00, 8'h21, 8'h00, 1, rv, ak);
      chk("R2 address latched at ale fall", rv, 8'h5A);
      xfer(0, 8'h00, 8'h00, 8'hFF, 0, rv, ak);
      chk("R3 no handshake without select", ak, 0);
      rd_exp("R3 deselected write ignored", 8'h00, 8'h5A);
      rd_exp("R11 unmapped read zero", 8'h7F, 8'h00);
      wr(8'h20, 8'hFF);
      rd_exp("R11 status write ignored", 8'h20, 8'h00);
      wr(8'h33, 8'h11);
      rd_exp("R11 unmapped write ignored", 8'h00, 8'h5A);

      // R9 sticky status and read-clear
      alarm = 16'h0008; tick(); tick(); alarm = 16'h0000; tick();
      rd_exp("R9 sticky bit seen", 8'h20, 8'h08);
      rd_exp("R9 cleared by read", 8'h20, 8'h00);
      alarm = 16'h0200; tick();
      rd_exp("R9 active alarm seen", 8'h21, 8'h02);
      rd_exp("R9 active alarm survives read", 8'h21, 8'h02);
      alarm = 16'h0000; tick();
      rd_exp("R9 set after release", 8'h21, 8'h02);
      rd_exp("R9 cleared after release", 8'h21, 8'h00);

      // R10 interrupt gating
      alarm = 16'h0001; tick(); alarm = 16'h0000; tick(); tick();
      chk("R10 masked while enable clear", irq_n, 1);
      wr(8'h00, 8'h80);
      chk("R10 asserted with enable", irq_n, 0);
      wr(8'h00, 8'h00);
      chk("R10 released when enable cleared", irq_n, 1);
      rd_exp("R9 pending bit read", 8'h20, 8'h01);

      // data strobe, asynchronous
      type_sel = 2'b01; tick();
      chk("R6 idle level data-strobe style", xfer_ack, 1);
      wr(8'h00, 8'h3C);
      rd_exp("R5 data-strobe read-back", 8'h00, 8'h3C);
      lat_check("R1 async latency");

      // separate strobes, synchronous
      type_sel = 2'b10; tick();
      wr(8'h00, 8'hC3);
      rd_exp("R4 sync separate read-back", 8'h00, 8'hC3);
      lat_check("R1 sync latency");

      // data strobe, synchronous
      type_sel = 2'b11; tick();
      wr(8'h00, 8'h96);
      rd_exp("R5 sync data-strobe read-back", 8'h00, 8'h96);
      lat_check("R1 sync data-strobe latency");

      done_run = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule